// File: doc/BRIEF.md
# Trigger-Driven Event Builder

This block sits at the top of a daisy-chained bus that serves up to eight readout concentrators. Each accepted level-1 trigger adds one event to a small pending count, because the front end can hold only a few analog events at a time. When no conversion is in progress, the builder pulses a conversion start for the oldest pending event. Once the front end reports that conversion has finished, the builder emits a header word that carries a 16-bit event number. It then raises a shared readout token for a programmable number of cycles.

While the token is high, the concentrators place their words on the bus. Each word is forwarded into the packet stream, in order, one cycle after it arrives. A countdown raises an early-warning pulse a fixed number of cycles before the token drops, so that the closing words can be prepared in time. After the token falls, two trailer words close the packet. The first trailer word is the number of data words collected. The second is a user word with one overrun bit per concentrator and a summary bit.

Top module: `event_builder`

## Requirements
- R1: After reset, busy_o, conv_start_o, token_o, tok_warn_o, pkt_valid_o and pkt_last_o are all 0.
- R2: A trigger sampled while the builder is idle with nothing pending raises conv_start_o for exactly one cycle, in the cycle right after the trigger edge.
- R3: At most DEPTH (4) events are pending. busy_o is 1 exactly while 4 are pending. A trigger sampled while busy_o is 1 is dropped.
- R4: conv_start_o never pulses while a conversion is running, that is, between a start pulse and conv_done_i. The next pending event starts one cycle after the cycle that shows pkt_last_o.
- R5: The header word holds the event number in bits [15:0]. The number is 0 for the first accepted trigger and rises by 1 per accepted trigger. Dropped triggers consume no number.
- R6: The header word and the rise of token_o appear two cycles after the cycle in which conv_done_i is sampled high. The token stays high for max(tok_len_i, 4) cycles, and tok_len_i is latched when the header is emitted.
- R7: tok_warn_o is a one-cycle pulse in the cycle that lies 4 cycles before the first cycle with token_o low.
- R8: A word on cc_data_i with cc_valid_i high during a token cycle appears on pkt_data_o with pkt_valid_o in the next cycle. Token cycles without cc_valid_i give an idle slot. cc_valid_i outside the token has no effect.
- R9: In the cycle after the last token slot, trailer word 0 carries the count of data words. In the next cycle, trailer word 1 carries the user word, with pkt_last_o set. In the user word, bit k (k < 8) is set if concentrator k raised cc_ovr_i[k] during the token, and bit 15 is the OR of those bits. cc_ovr_i outside the token is ignored.
- R10: pkt_last_o is only ever high together with pkt_valid_o. The packet ends one cycle after trailer word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Level-1 accept, one pulse per trigger |
| busy_o | output | 1 | Pending storage full; new triggers are dropped |
| conv_start_o | output | 1 | One-cycle request to convert the oldest pending event |
| conv_done_i | input | 1 | Front end reports that conversion is complete |
| tok_len_i | input | TOKW | Token length in cycles, latched at the header |
| token_o | output | 1 | Shared readout token to all concentrators |
| tok_warn_o | output | 1 | Early warning that the token is about to drop |
| cc_valid_i | input | 1 | Concentrator word present on the bus |
| cc_data_i | input | WORD_W | Concentrator data word |
| cc_ovr_i | input | NCC | Per-concentrator zero-suppression overrun flags |
| pkt_valid_o | output | 1 | Packet word valid |
| pkt_data_o | output | WORD_W | Packet word: header, data or trailer |
| pkt_last_o | output | 1 | Final word of the packet |

## Verification
Each result has a fixed latency:
- conv_start_o comes one cycle after the trigger edge.
- The header and the token rise come two cycles after conv_done_i is sampled.
- A forwarded concentrator word comes one cycle after its slot.
- The two trailer words come one and two cycles after the token falls.
- The next conversion start comes one cycle after the last word.

The bench drives inputs and reads outputs at falling edges, and it advances one cycle at a time through each packet. At every cycle it compares the output against a value it derives from the token length, the slot index, the valid pattern and the overrun mask. The token length is swept from 1 to 12, which covers the lengths below the minimum. A burst of five triggers exercises the pending limit.

// File: rtl/evb_pkg.sv
package evb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CONV,
      ST_HDR,
      ST_TOK,
      ST_TRL0,
      ST_TRL1
   } evb_state_e;

   typedef enum logic [1:0] {
      W_HDR,
      W_DATA,
      W_CNT,
      W_USER
   } evb_word_e;
endpackage

// File: rtl/evb_pend_ctr.sv
module evb_pend_ctr #(
   parameter int DEPTH = 4,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trig,
   input  logic          release_ev,
   output logic          accept,
   output logic          busy,
   output logic [CW-1:0] count
);
   initial begin : elab_chk
      assert (DEPTH >= 1) else $fatal(1, "DEPTH must be at least 1");
   end

   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   assign busy   = (count == FULL);
   assign accept = trig && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         case ({accept, release_ev})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/evb_tok_timer.sv
module evb_tok_timer #(
   parameter int TOKW  = 8,
   parameter int EARLY = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [TOKW-1:0] len,
   output logic            active,
   output logic            warn,
   output logic            final_cyc
);
   initial begin : elab_chk
      assert (EARLY >= 1) else $fatal(1, "EARLY must be at least 1");
      assert (EARLY < (1 << TOKW)) else $fatal(1, "EARLY does not fit TOKW");
   end

   localparam logic [TOKW-1:0] MIN_LEN = TOKW'(EARLY);

   logic [TOKW-1:0] remain;
   logic [TOKW-1:0] eff_len;

   assign eff_len   = (len < MIN_LEN) ? MIN_LEN : len;
   assign active    = (remain != '0);
   assign warn      = (remain == MIN_LEN);
   assign final_cyc = (remain == TOKW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (load) begin
         remain <= eff_len;
      end else if (active) begin
         remain <= remain - TOKW'(1);
      end
   end
endmodule

// File: rtl/evb_packer.sv
module evb_packer
   import evb_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int NCC      = 8,
   parameter int EVW      = 16,
   parameter bit ANY_FLAG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              emit,
   input  evb_word_e         kind,
   input  logic              token_act,
   input  logic              cc_valid,
   input  logic [WORD_W-1:0] cc_data,
   input  logic [NCC-1:0]    cc_ovr,
   input  logic [EVW-1:0]    evnum,
   output logic              pkt_valid,
   output logic [WORD_W-1:0] pkt_data,
   output logic              pkt_last
);
   initial begin : elab_chk
      assert (NCC <= WORD_W - 2) else $fatal(1, "NCC too wide for user word");
      assert (EVW <= WORD_W) else $fatal(1, "EVW wider than WORD_W");
   end

   logic [WORD_W-1:0] wcount;
   logic [NCC-1:0]    ovr_acc;
   logic [WORD_W-1:0] user_w;
   logic [WORD_W-1:0] hdr_w;
   logic [WORD_W-1:0] word_mux;

   assign hdr_w = WORD_W'(evnum);

   generate
      if (ANY_FLAG) begin : g_flag
         assign user_w = {|ovr_acc, {(WORD_W - 1 - NCC){1'b0}}, ovr_acc};
      end else begin : g_noflag
         assign user_w = {{(WORD_W - NCC){1'b0}}, ovr_acc};
      end
   endgenerate

   always_comb begin
      case (kind)
         W_HDR:   word_mux = hdr_w;
         W_DATA:  word_mux = cc_data;
         W_CNT:   word_mux = wcount;
         W_USER:  word_mux = user_w;
         default: word_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcount  <= '0;
         ovr_acc <= '0;
      end else if (clr) begin
         wcount  <= '0;
         ovr_acc <= '0;
      end else if (token_act) begin
         ovr_acc <= ovr_acc | cc_ovr;
         if (cc_valid) begin
            wcount <= wcount + WORD_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pkt_valid <= 1'b0;
         pkt_data  <= '0;
         pkt_last  <= 1'b0;
      end else begin
         pkt_valid <= emit;
         pkt_last  <= emit && (kind == W_USER);
         if (emit) begin
            pkt_data <= word_mux;
         end
      end
   end
endmodule

// File: rtl/event_builder.sv
module event_builder
   import evb_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int NCC      = 8,
   parameter int DEPTH    = 4,
   parameter int TOKW     = 8,
   parameter int EARLY    = 4,
   parameter int EVW      = 16,
   parameter bit ANY_FLAG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   output logic              busy_o,
   output logic              conv_start_o,
   input  logic              conv_done_i,
   input  logic [TOKW-1:0]   tok_len_i,
   output logic              token_o,
   output logic              tok_warn_o,
   input  logic              cc_valid_i,
   input  logic [WORD_W-1:0] cc_data_i,
   input  logic [NCC-1:0]    cc_ovr_i,
   output logic              pkt_valid_o,
   output logic [WORD_W-1:0] pkt_data_o,
   output logic              pkt_last_o
);
   localparam int CW = $clog2(DEPTH + 1);

   initial begin : elab_chk
      assert (NCC >= 1 && NCC <= 8) else $fatal(1, "NCC must be 1..8");
   end

   evb_state_e      state, state_nx;
   logic [CW-1:0]   pend_cnt;
   logic            pend_accept;
   logic            release_ev;
   logic            start_nx;
   logic            conv_start_q;
   logic [EVW-1:0]  evnum;
   logic            tmr_load;
   logic            tmr_active;
   logic            tmr_warn;
   logic            tmr_final;
   logic            pk_emit;
   logic            pk_clr;
   evb_word_e       pk_kind;

   evb_pend_ctr #(.DEPTH(DEPTH)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig       (trig_i),
      .release_ev (release_ev),
      .accept     (pend_accept),
      .busy       (busy_o),
      .count      (pend_cnt)
   );

   evb_tok_timer #(.TOKW(TOKW), .EARLY(EARLY)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tmr_load),
      .len       (tok_len_i),
      .active    (tmr_active),
      .warn      (tmr_warn),
      .final_cyc (tmr_final)
   );

   evb_packer #(
      .WORD_W   (WORD_W),
      .NCC      (NCC),
      .EVW      (EVW),
      .ANY_FLAG (ANY_FLAG)
   ) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (pk_clr),
      .emit      (pk_emit),
      .kind      (pk_kind),
      .token_act (tmr_active),
      .cc_valid  (cc_valid_i),
      .cc_data   (cc_data_i),
      .cc_ovr    (cc_ovr_i),
      .evnum     (evnum),
      .pkt_valid (pkt_valid_o),
      .pkt_data  (pkt_data_o),
      .pkt_last  (pkt_last_o)
   );

   always_comb begin
      state_nx   = state;
      start_nx   = 1'b0;
      tmr_load   = 1'b0;
      pk_emit    = 1'b0;
      pk_clr     = 1'b0;
      pk_kind    = W_DATA;
      release_ev = 1'b0;
      case (state)
         ST_IDLE: begin
            if (pend_cnt != '0 || pend_accept) begin
               start_nx = 1'b1;
               state_nx = ST_CONV;
            end
         end
         ST_CONV: begin
            if (conv_done_i) begin
               state_nx = ST_HDR;
            end
         end
         ST_HDR: begin
            tmr_load = 1'b1;
            pk_clr   = 1'b1;
            pk_emit  = 1'b1;
            pk_kind  = W_HDR;
            state_nx = ST_TOK;
         end
         ST_TOK: begin
            pk_emit = cc_valid_i;
            pk_kind = W_DATA;
            if (tmr_final) begin
               state_nx = ST_TRL0;
            end
         end
         ST_TRL0: begin
            pk_emit  = 1'b1;
            pk_kind  = W_CNT;
            state_nx = ST_TRL1;
         end
         ST_TRL1: begin
            pk_emit    = 1'b1;
            pk_kind    = W_USER;
            release_ev = 1'b1;
            state_nx   = ST_IDLE;
         end
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         conv_start_q <= 1'b0;
         evnum        <= '0;
      end else begin
         state        <= state_nx;
         conv_start_q <= start_nx;
         if (release_ev) begin
            evnum <= evnum + EVW'(1);
         end
      end
   end

   assign conv_start_o = conv_start_q;
   assign token_o      = tmr_active;
   assign tok_warn_o   = tmr_warn;
endmodule

// File: rtl/evb_checker.sv
module evb_checker #(
   parameter int DEPTH = 4,
   parameter int EARLY = 4,
   parameter int CW    = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          token_o,
   input logic          tok_warn_o,
   input logic          conv_start_o,
   input logic          conv_done_i,
   input logic          pkt_valid_o,
   input logic          pkt_last_o,
   input logic [CW-1:0] pend_cnt
);
   logic       tok_prev;
   logic       conv_running;
   logic [7:0] tok_run;
   logic [7:0] since_warn;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tok_prev     <= 1'b0;
         conv_running <= 1'b0;
         tok_run      <= '0;
         since_warn   <= '0;
      end else begin
         tok_prev <= token_o;
         if (conv_start_o) conv_running <= 1'b1;
         else if (conv_done_i) conv_running <= 1'b0;
         if (!token_o) tok_run <= '0;
         else if (tok_run != 8'hFF) tok_run <= tok_run + 8'd1;
         if (tok_warn_o) since_warn <= 8'd1;
         else if (since_warn != 8'd0 && since_warn != 8'hFF)
            since_warn <= since_warn + 8'd1;
      end
   end

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pend_cnt <= CW'(DEPTH));

   assert_single_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |-> !conv_running);

   assert_token_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_prev && !token_o) |-> (tok_run >= 8'(EARLY)));

   assert_warn_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_prev && !token_o) |-> (since_warn == 8'(EARLY)));

   assert_hdr_at_token_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(token_o) |-> (pkt_valid_o && !pkt_last_o));

   assert_last_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_last_o |-> pkt_valid_o);
endmodule

bind event_builder evb_checker #(.DEPTH(DEPTH), .EARLY(EARLY), .CW(CW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .token_o      (token_o),
   .tok_warn_o   (tok_warn_o),
   .conv_start_o (conv_start_o),
   .conv_done_i  (conv_done_i),
   .pkt_valid_o  (pkt_valid_o),
   .pkt_last_o   (pkt_last_o),
   .pend_cnt     (pend_cnt)
);

// File: tb/event_builder_test.sv
`timescale 1ns/1ps
module event_builder_test;
   localparam int WORD_W = 16;
   localparam int NCC    = 8;
   localparam int TOKW   = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              trig_i = 1'b0;
   logic              busy_o;
   logic              conv_start_o;
   logic              conv_done_i = 1'b0;
   logic [TOKW-1:0]   tok_len_i = '0;
   logic              token_o;
   logic              tok_warn_o;
   logic              cc_valid_i = 1'b0;
   logic [WORD_W-1:0] cc_data_i = '0;
   logic [NCC-1:0]    cc_ovr_i = '0;
   logic              pkt_valid_o;
   logic [WORD_W-1:0] pkt_data_o;
   logic              pkt_last_o;

   int checks = 0;
   int fails  = 0;
   int exp_pend = 0;
   int exp_ev = 0;

   always #2.5 clk = ~clk;

   event_builder uut (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .busy_o(busy_o),
      .conv_start_o(conv_start_o), .conv_done_i(conv_done_i),
      .tok_len_i(tok_len_i), .token_o(token_o), .tok_warn_o(tok_warn_o),
      .cc_valid_i(cc_valid_i), .cc_data_i(cc_data_i), .cc_ovr_i(cc_ovr_i),
      .pkt_valid_o(pkt_valid_o), .pkt_data_o(pkt_data_o), .pkt_last_o(pkt_last_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic logic [15:0] dat(input int ev, input int i);
      return {ev[7:0], i[7:0]} ^ 16'h5A00;
   endfunction

   function automatic bit vld(input int len, input int i);
      return ((i + len) % 3) != 0;
   endfunction

   function automatic logic [7:0] omask(input int len);
      if (len % 3 == 0) return 8'h00;
      return (8'h01 << (len % 8)) | 8'h40;
   endfunction

   // trigger from idle with nothing pending: start expected next cycle
   task automatic trig_idle();
      trig_i = 1'b1;
      tick();
      trig_i = 1'b0;
      exp_pend++;
      check("R2 conv_start after trigger", conv_start_o, 1);
      check("R3 busy after single trigger", busy_o, 0);
   endtask

   // starts in a cycle where a conversion is running
   task automatic run_readout(input int len);
      int L;
      int cnt;
      logic [7:0] m;
      L = (len < 4) ? 4 : len;
      m = omask(len);
      cnt = 0;
      tok_len_i = TOKW'(len);
      tick();
      check("R2 start is single cycle", conv_start_o, 0);
      check("R6 no token before done", token_o, 0);
      conv_done_i = 1'b1;
      tick();
      conv_done_i = 1'b0;
      // header cycle: token low, bus activity must be ignored
      check("R6 token low in header prep", token_o, 0);
      cc_valid_i = 1'b1;
      cc_data_i  = 16'hDEAD;
      cc_ovr_i   = 8'hFF;
      tick();
      check("R6 header valid", pkt_valid_o, 1);
      check("R5 header event number", pkt_data_o, exp_ev[15:0]);
      for (int i = 0; i < L; i++) begin
         if (i > 0) begin
            check("R8 slot valid", pkt_valid_o, vld(len, i - 1));
            if (vld(len, i - 1)) check("R8 slot data", pkt_data_o, dat(exp_ev, i - 1));
         end
         check("R6 token high", token_o, 1);
         check("R7 warning position", tok_warn_o, (i == L - 4));
         cc_valid_i = vld(len, i);
         cc_data_i  = dat(exp_ev, i);
         cc_ovr_i   = (i == 0) ? (m & 8'h0F) : ((i == L - 1) ? (m & 8'hF0) : 8'h00);
         if (vld(len, i)) cnt++;
         if (i == 1) tok_len_i = '0;
         tick();
      end
      check("R6 token low after length", token_o, 0);
      check("R7 no warning after token", tok_warn_o, 0);
      check("R8 last slot valid", pkt_valid_o, vld(len, L - 1));
      if (vld(len, L - 1)) check("R8 last slot data", pkt_data_o, dat(exp_ev, L - 1));
      cc_valid_i = 1'b1;
      cc_data_i  = 16'hBEEF;
      cc_ovr_i   = 8'hFF;
      tick();
      cc_valid_i = 1'b0;
      cc_ovr_i   = 8'h00;
      check("R9 trailer0 valid", pkt_valid_o, 1);
      check("R9 trailer0 count", pkt_data_o, cnt);
      check("R10 trailer0 not last", pkt_last_o, 0);
      tick();
      exp_pend--;
      exp_ev++;
      check("R9 trailer1 valid", pkt_valid_o, 1);
      check("R9 trailer1 user word", pkt_data_o, {(m != 8'h00), 7'b0, m});
      check("R10 last flag", pkt_last_o, 1);
      tick();
      check("R10 idle after last", pkt_valid_o, 0);
      check("R4 next start after last", conv_start_o, (exp_pend > 0));
      check("R3 busy level", busy_o, (exp_pend == 4));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      check("R1 busy", busy_o, 0);
      check("R1 conv_start", conv_start_o, 0);
      check("R1 token", token_o, 0);
      check("R1 warn", tok_warn_o, 0);
      check("R1 pkt_valid", pkt_valid_o, 0);
      check("R1 pkt_last", pkt_last_o, 0);

      // sweep token length, covering values below the minimum
      for (int len = 1; len <= 12; len++) begin
         trig_idle();
         run_readout(len);
      end

      // burst of five triggers: four accepted, fifth dropped
      trig_i = 1'b1;
      tick();
      check("R2 start on burst", conv_start_o, 1);
      for (int k = 1; k < 5; k++) begin
         if (k == 4) check("R3 busy when four pending", busy_o, 1);
         else check("R3 not busy below four", busy_o, 0);
         tick();
         check("R4 no second start", conv_start_o, 0);
      end
      trig_i = 1'b0;
      exp_pend = 4;
      check("R3 busy after dropped trigger", busy_o, 1);
      for (int e = 0; e < 4; e++) begin
         run_readout(5 + e);
         if (e == 0) check("R3 busy cleared after release", busy_o, 0);
      end
      // dropped trigger consumed no event number
      trig_idle();
      run_readout(7);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule